// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a serial peripheral master that runs a short list of transfers on its own. The host fills a small table of command entries through a write port. Each entry holds the outgoing word, how many bits to send, which chip-select line to use, and a flag that ends the list. On a start pulse the controller works through the entries from index zero. For each entry it drives one word out on MOSI, most significant bit first, and captures the same number of bits from MISO. The received word is stored beside the outgoing word in that entry, and the host reads it back through a read port.

Clock polarity, clock phase and the clock divider are taken from inputs in the cycle that start is accepted. They stay fixed until the queue halts. A wrap input sends the controller back to entry zero after the end of the list, so the transfers repeat with no further host action. The host can rewrite outgoing words while the queue runs. The controller reports a busy level, the index of the entry in progress, and a single-cycle done pulse.

Top module: `qspi_queue_master`

## Requirements
- R1: An accepted start runs the entries in ascending index order from entry 0. Each entry uses the outgoing word, length, select index and end flag that were written through the write port.
- R2: One SCLK half period lasts div+1 system clocks. SCLK rests at the CPOL level whenever no clock pulses are being produced. Each selected line goes low one half period before the first clock edge.
- R3: With CPHA=0, MOSI carries the first bit from the moment the select line goes low and changes at each trailing edge. MISO is sampled at each leading edge.
- R4: With CPHA=1, MOSI is 0 until the first leading edge and changes at each leading edge. MISO is sampled at each trailing edge.
- R5: Entry length is 5 bits. Values 1 to 16 give that many bits, and 0 or any value above 16 gives 16 bits. Bits go out MSB first. Each sampled bit enters the receive word as its new LSB. The stored received word is right-aligned, with its upper bits zero.
- R6: During an entry, only cs_n[select index] is low. It stays low from one half period before the first edge until one half period after the last trailing edge. All select lines are high for one half period between entries and whenever the controller is idle.
- R7: With wrap low, the queue halts after the first entry whose end flag is set, or after entry DEPTH-1. Entries after that point are not transferred, and their received words are left unchanged.
- R8: With wrap high, the entry after an end point is entry 0. The queue halts at the first end point reached after wrap goes low.
- R9: busy goes high in the cycle after start is accepted and falls when the queue halts. done is high for exactly the first idle cycle after a run.
- R10: A start while busy is high is ignored. cur_idx shows the entry being transferred and changes only while all select lines are high.
- R11: After reset, every select line is high, busy and done are low, SCLK is low, and every stored received word reads zero.
- R12: Changes to cpol, cpha or div while busy is high do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one queue entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_tx | input | DATA_W | Outgoing word |
| wr_len | input | 5 | Bit count for the entry |
| wr_sel | input | 2 | Chip-select index for the entry |
| wr_stop | input | 1 | End-of-list flag for the entry |
| rd_idx | input | IDX_W | Entry index to read back |
| rd_rx | output | DATA_W | Received word of entry rd_idx |
| start | input | 1 | Begin running the queue when idle |
| wrap | input | 1 | Continue at entry 0 after an end point |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase select |
| div | input | DIV_W | Half-period length minus one, in system clocks |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |
| busy | output | 1 | Queue running |
| done | output | 1 | One-cycle pulse when the queue halts |
| cur_idx | output | IDX_W | Entry in progress |

## Verification
The bench runs all four clock modes with several dividers. A phase error would move MOSI changes onto the sampling edge, and the received words would come back shifted by one bit. Lengths 1, 8, 12, 16, 0 and 20 are covered, so a design that treats the length field literally would send zero or too many bits and misalign the stored word. Runs that end at an end flag, at the last entry, and after several wraps would expose extra or missing transfers and cur_idx values that do not return to zero. A start pulse and changes to mode and divider during a wrapping run would show up as restarted indices or altered SCLK timing in a design that fails to latch its configuration.

// File: rtl/qsm_pkg.sv
package qsm_pkg;
  localparam int LEN_W = 5;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } qsm_state_e;
endpackage

// File: rtl/qsm_clkdiv.sv
module qsm_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qsm_entry_store.sv
module qsm_entry_store
  import qsm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_tx,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_stop,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_rx,
  input  logic [IDX_W-1:0]  q_idx,
  output logic [DATA_W-1:0] q_tx,
  output logic [LEN_W-1:0]  q_len,
  output logic [SEL_W-1:0]  q_sel,
  output logic              q_stop,
  input  logic [IDX_W-1:0]  h_idx,
  output logic [DATA_W-1:0] h_rx
);
  logic [DATA_W-1:0] tx_q   [DEPTH];
  logic [DATA_W-1:0] tx_d   [DEPTH];
  logic [DATA_W-1:0] rx_q   [DEPTH];
  logic [DATA_W-1:0] rx_d   [DEPTH];
  logic [LEN_W-1:0]  len_q  [DEPTH];
  logic [LEN_W-1:0]  len_d  [DEPTH];
  logic [SEL_W-1:0]  sel_q  [DEPTH];
  logic [SEL_W-1:0]  sel_d  [DEPTH];
  logic              stop_q [DEPTH];
  logic              stop_d [DEPTH];

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    len_d  = len_q;
    sel_d  = sel_q;
    stop_d = stop_q;
    if (wr_en) begin
      tx_d[wr_idx]   = wr_tx;
      len_d[wr_idx]  = wr_len;
      sel_d[wr_idx]  = wr_sel;
      stop_d[wr_idx] = wr_stop;
    end
    if (wb_en) rx_d[wb_idx] = wb_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '{default: '0};
      rx_q   <= '{default: '0};
      len_q  <= '{default: '0};
      sel_q  <= '{default: '0};
      stop_q <= '{default: 1'b0};
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      len_q  <= len_d;
      sel_q  <= sel_d;
      stop_q <= stop_d;
    end
  end

  assign q_tx   = tx_q[q_idx];
  assign q_len  = len_q[q_idx];
  assign q_sel  = sel_q[q_idx];
  assign q_stop = stop_q[q_idx];
  assign h_rx   = rx_q[h_idx];
endmodule

// File: rtl/qsm_shifter.sv
module qsm_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W:0]   load_word,
  input  logic              tx_shift,
  input  logic              rx_sample,
  input  logic              miso,
  output logic              mosi_bit,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W:0]   sh_q, sh_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    sh_d = sh_q;
    rx_d = rx_q;
    if (load) begin
      sh_d = load_word;
      rx_d = '0;
    end else begin
      if (tx_shift)  sh_d = {sh_q[DATA_W-1:0], 1'b0};
      if (rx_sample) rx_d = {rx_q[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      rx_q <= '0;
    end else begin
      sh_q <= sh_d;
      rx_q <= rx_d;
    end
  end

  assign mosi_bit = sh_q[DATA_W];
  assign rx_word  = rx_q;
endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
  import qsm_pkg::*;
#(
  parameter int  DATA_W = 16,
  parameter int  DEPTH  = 4,
  parameter int  NCS    = 4,
  parameter int  DIV_W  = 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_tx,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_stop,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_rx,
  input  logic              start,
  input  logic              wrap,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  div,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  cur_idx
);
  localparam int HALF_W = LEN_W + 1;

  qsm_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_sel;
  logic [HALF_W-1:0] h_q, h_d, last_h;
  logic [LEN_W-1:0]  nbits_q, nbits_d, q_len, n_eff;
  logic [SEL_W-1:0]  sel_q, sel_d, q_sel;
  logic              stop_q, stop_d, q_stop;
  logic              cpol_q, cpol_d, cpha_q, cpha_d, done_q, done_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DATA_W-1:0] q_tx, aligned, rx_word;
  logic [DATA_W:0]   load_word;
  logic              run, tick, lead, trail, load, wb_en, last_ent;
  logic              cpha_ld, mosi_bit, cs_act;

  qsm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  qsm_entry_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tx(wr_tx), .wr_len(wr_len),
    .wr_sel(wr_sel), .wr_stop(wr_stop),
    .wb_en(wb_en), .wb_idx(idx_q), .wb_rx(rx_word),
    .q_idx(idx_sel), .q_tx(q_tx), .q_len(q_len), .q_sel(q_sel), .q_stop(q_stop),
    .h_idx(rd_idx), .h_rx(rd_rx)
  );

  qsm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
    .tx_shift(cpha_q ? lead : trail), .rx_sample(cpha_q ? trail : lead),
    .miso(miso), .mosi_bit(mosi_bit), .rx_word(rx_word)
  );

  // entry decode and edge events
  always_comb begin
    run      = (st_q != ST_IDLE);
    last_ent = stop_q || (idx_q == IDX_W'(DEPTH - 1));
    idx_sel  = (st_q == ST_IDLE || last_ent) ? '0 : idx_q + IDX_W'(1);
    n_eff    = (q_len == '0 || q_len > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : q_len;
    aligned  = q_tx << (LEN_W'(DATA_W) - n_eff);
    cpha_ld  = (st_q == ST_IDLE) ? cpha : cpha_q;
    load_word = cpha_ld ? {1'b0, aligned} : {aligned, 1'b0};
    last_h   = {nbits_q, 1'b0} - HALF_W'(1);
    lead     = tick && (st_q == ST_SETUP ||
               (st_q == ST_SHIFT && h_q[0] && h_q != last_h));
    trail    = tick && (st_q == ST_SHIFT) && !h_q[0];
  end

  // next state
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    h_d     = h_q;
    nbits_d = nbits_q;
    sel_d   = sel_q;
    stop_d  = stop_q;
    cpol_d  = cpol_q;
    cpha_d  = cpha_q;
    div_d   = div_q;
    done_d  = 1'b0;
    load    = 1'b0;
    wb_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cpol_d = cpol;
        cpha_d = cpha;
        div_d  = div;
        if (start) begin
          st_d = ST_SETUP;
          load = 1'b1;
        end
      end
      ST_SETUP: if (tick) begin
        st_d = ST_SHIFT;
        h_d  = '0;
      end
      ST_SHIFT: if (tick) begin
        if (h_q == last_h) begin
          st_d  = ST_GAP;
          wb_en = 1'b1;
        end else begin
          h_d = h_q + HALF_W'(1);
        end
      end
      ST_GAP: if (tick) begin
        if (last_ent && !wrap) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_SETUP;
          load = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (load) begin
      idx_d   = idx_sel;
      nbits_d = n_eff;
      sel_d   = q_sel;
      stop_d  = q_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      h_q     <= '0;
      nbits_q <= '0;
      sel_q   <= '0;
      stop_q  <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      div_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      h_q     <= h_d;
      nbits_q <= nbits_d;
      sel_q   <= sel_d;
      stop_q  <= stop_d;
      cpol_q  <= cpol_d;
      cpha_q  <= cpha_d;
      div_q   <= div_d;
      done_q  <= done_d;
    end
  end

  assign cs_act  = (st_q == ST_SETUP) || (st_q == ST_SHIFT);
  assign sclk    = cpol_q ^ ((st_q == ST_SHIFT) && !h_q[0]);
  assign mosi    = cs_act & mosi_bit;
  assign busy    = run;
  assign done    = done_q;
  assign cur_idx = idx_q;

  for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
    assign cs_n[gi] = ~(cs_act && (sel_q == SEL_W'(gi)));
  end
endmodule

// File: rtl/qsm_checker.sv
module qsm_checker #(
  parameter int NCS   = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCS-1:0]   cs_n,
  input logic             sclk,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] cur_idx
);
  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R6
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R2
  sclk_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (&cs_n)) |-> $stable(sclk));
  // R10
  idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(cur_idx)) |-> $past(&cs_n));
endmodule

bind qspi_queue_master qsm_checker #(.NCS(NCS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .busy(busy), .done(done), .cur_idx(cur_idx)
);

// File: tb/qspi_queue_master_tb_top.sv
module qspi_queue_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_stop, start, wrap, cpol, cpha, miso;
  logic [1:0]  wr_idx, rd_idx, wr_sel, cur_idx;
  logic [15:0] wr_tx, rd_rx;
  logic [4:0]  wr_len;
  logic [7:0]  div;
  logic        sclk, mosi, busy, done;
  logic [3:0]  cs_n;

  int n_checks = 0, n_fail = 0, cyc = 0, runs = 0, done_seen = 0, wraps = 0;
  bit cmp_en = 0;

  always #10 clk = ~clk;

  qspi_queue_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tx(wr_tx),
    .wr_len(wr_len), .wr_sel(wr_sel), .wr_stop(wr_stop), .rd_idx(rd_idx),
    .rd_rx(rd_rx), .start(start), .wrap(wrap), .cpol(cpol), .cpha(cpha),
    .div(div), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .busy(busy), .done(done), .cur_idx(cur_idx)
  );

  // behavioural reference model
  int m_st, m_cnt, m_h, m_idx, m_n, m_sel, m_shifts, m_div, m_tx, m_rx;
  bit m_stop, m_cpol, m_cpha, m_done;
  int e_tx[4], e_len[4], e_sel[4], e_rx[4];
  bit e_stop[4];

  task automatic take_entry(input int i);
    m_idx = i;
    m_tx = e_tx[i];
    m_n = (e_len[i] == 0 || e_len[i] > 16) ? 16 : e_len[i];
    m_sel = e_sel[i];
    m_stop = e_stop[i];
    m_shifts = 0;
    m_rx = 0;
  endtask

  always @(posedge clk) begin
    bit tk, ld, tr, endp;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_h = 0; m_idx = 0; m_n = 16; m_sel = 0;
      m_shifts = 0; m_div = 0; m_tx = 0; m_rx = 0;
      m_stop = 0; m_cpol = 0; m_cpha = 0; m_done = 0;
      for (int i = 0; i < 4; i++) begin
        e_tx[i] = 0; e_len[i] = 0; e_sel[i] = 0; e_rx[i] = 0; e_stop[i] = 0;
      end
    end else begin
      tk = (m_st != 0) && (m_cnt == m_div);
      ld = tk && (m_st == 1 || (m_st == 2 && (m_h % 2 == 1) && m_h != 2 * m_n - 1));
      tr = tk && (m_st == 2) && (m_h % 2 == 0);
      m_cnt = (m_st == 0 || tk) ? 0 : m_cnt + 1;
      if (m_cpha ? tr : ld) m_rx = ((m_rx << 1) | int'(miso)) & 'hFFFF;
      if (m_cpha ? ld : tr) m_shifts++;
      m_done = 0;
      case (m_st)
        0: begin
          m_cpol = cpol; m_cpha = cpha; m_div = int'(div);
          if (start) begin take_entry(0); m_st = 1; end
        end
        1: if (tk) begin m_st = 2; m_h = 0; end
        2: if (tk) begin
          if (m_h == 2 * m_n - 1) begin e_rx[m_idx] = m_rx; m_st = 3; end
          else m_h++;
        end
        default: if (tk) begin
          endp = m_stop || m_idx == 3;
          if (endp && !wrap) begin m_st = 0; m_done = 1; end
          else begin take_entry(endp ? 0 : m_idx + 1); m_st = 1; end
        end
      endcase
      if (wr_en) begin
        e_tx[wr_idx] = int'(wr_tx); e_len[wr_idx] = int'(wr_len);
        e_sel[wr_idx] = int'(wr_sel); e_stop[wr_idx] = wr_stop;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit act_cs, e_mosi;
    if (rst_n && cmp_en) begin
      act_cs = (m_st == 1 || m_st == 2);
      e_mosi = 0;
      if (act_cs) begin
        if (!m_cpha) e_mosi = (m_shifts < m_n) ? m_tx[m_n-1-m_shifts] : 1'b0;
        else         e_mosi = (m_shifts == 0) ? 1'b0 : m_tx[m_n-m_shifts];
      end
      chk("R2", "sclk", 32'(sclk), 32'(m_cpol ^ (m_st == 2 && m_h % 2 == 0)));
      chk("R6", "cs_n", 32'(cs_n), act_cs ? 32'(4'hF & ~(4'b1 << m_sel)) : 32'hF);
      chk(m_cpha ? "R4" : "R3", "mosi", 32'(mosi), 32'(e_mosi));
      chk("R9", "busy", 32'(busy), 32'(m_st != 0));
      chk("R9", "done", 32'(done), 32'(m_done));
      chk("R10", "cur_idx", 32'(cur_idx), 32'(m_idx));
      if (done) done_seen++;
    end
  end

  always @(negedge clk) begin
    miso <= 1'($urandom);
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic put(input int i, input int tx, input int len, input int sel, input bit stp);
    @(negedge clk);
    wr_en = 1; wr_idx = 2'(i); wr_tx = 16'(tx); wr_len = 5'(len);
    wr_sel = 2'(sel); wr_stop = stp;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic go(input bit p, input bit h, input int d);
    @(negedge clk);
    cpol = p; cpha = h; div = 8'(d);
    repeat (2) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    runs++;
    @(negedge clk);
  endtask

  task automatic rx_chk(input int i, input string req);
    @(negedge clk);
    rd_idx = 2'(i);
    #1;
    chk(req, "rd_rx", 32'(rd_rx), 32'(e_rx[i]));
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_tx = 0; wr_len = 0; wr_sel = 0;
    wr_stop = 0; rd_idx = 0; start = 0; wrap = 0; cpol = 0; cpha = 0; div = 0;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk("R11", "cs_n", 32'(cs_n), 32'hF);
    chk("R11", "busy", 32'(busy), 0);
    chk("R11", "done", 32'(done), 0);
    chk("R11", "sclk", 32'(sclk), 0);
    chk("R11", "rd_rx", 32'(rd_rx), 0);
    @(negedge clk);
    rst_n = 1;
    cmp_en = 1;

    // R1 R5 R7: lengths 8, 12, 16, end flag on entry 2
    put(0, 'h00A5, 8, 0, 0);
    put(1, 'h0ABC, 12, 1, 0);
    put(2, 'hBEEF, 16, 2, 1);
    put(3, 'h1234, 16, 3, 0);
    go(0, 0, 1);
    for (int i = 0; i < 3; i++) rx_chk(i, "R5");
    rd_idx = 2'd3; #1;
    chk("R7", "entry 3 untouched", 32'(rd_rx), 0);
    go(1, 1, 0);
    for (int i = 0; i < 3; i++) rx_chk(i, "R4");
    go(0, 1, 2);
    for (int i = 0; i < 3; i++) rx_chk(i, "R4");
    go(1, 0, 0);
    for (int i = 0; i < 3; i++) rx_chk(i, "R3");

    // R7: no end flag, halts after last entry; length 0 means 16
    put(2, 'hBEEF, 16, 2, 0);
    put(3, 'hC3C3, 0, 3, 0);
    go(0, 0, 0);
    chk("R7", "cur_idx at halt", 32'(cur_idx), 3);
    rx_chk(3, "R5");

    // R5: length 1 and out-of-range length 20
    put(0, 'h0001, 1, 2, 0);
    put(1, 'hF00D, 20, 0, 0);
    put(2, 'h005A, 8, 1, 1);
    go(1, 1, 1);
    for (int i = 0; i < 3; i++) rx_chk(i, "R5");

    // R8 R10 R12: wrapping run, restart attempt and config changes mid-run
    @(negedge clk);
    wrap = 1; cpol = 0; cpha = 1; div = 0;
    repeat (2) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    begin
      int prev;
      prev = int'(cur_idx);
      while (wraps < 3) begin
        @(negedge clk);
        if (busy && cur_idx == 0 && prev != 0) wraps++;
        prev = int'(cur_idx);
        if (wraps == 1 && cur_idx == 1) begin
          start = 1; cpha = 0; cpol = 1; div = 3;
          @(negedge clk);
          start = 0;
          chk("R10", "start ignored", 32'(cur_idx), 32'(m_idx));
          chk("R12", "sclk after cfg change", 32'(sclk), 32'(m_cpol ^ (m_st == 2 && m_h % 2 == 0)));
          prev = int'(cur_idx);
        end
      end
    end
    wrap = 0;
    while (!done) @(negedge clk);
    runs++;
    @(negedge clk);
    chk("R8", "wrap count", 32'(wraps >= 3), 1);
    for (int i = 0; i < 3; i++) rx_chk(i, "R8");
    chk("R9", "done pulses", 32'(done_seen), 32'(runs));

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule